// File: doc/BRIEF.md
# Dual-Direction Latch/Register Bus Transceiver

This block joins two 18-bit data ports, called A and B. Each direction has its own storage element. That element can pass data straight through, hold it like a level latch, or load it on a rising edge of that direction's capture strobe. Each direction also has its own drive enable. The A-to-B enable is active high and the B-to-A enable is active low.

The ports are modelled as separate input, output and enable vectors rather than bidirectional pads. A pad wrapper can map each output pair onto a tri-state wire, and places Z wherever the enable output is low.

The whole block is synchronous to one system clock with a synchronous active-high reset. The latch enables and capture strobes are sampled on that clock. A strobe edge is a change of the sampled level between two consecutive system cycles. Every output is registered, so a result is visible one system cycle after the inputs that caused it.

Top module: `dual_path_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both data outputs become 0 and both enable outputs become 0 after that edge. The strobe level present during reset is taken as the previous level, so it never counts as an edge afterwards.
- R2: When a direction's latch enable is 1 at a clock edge, that direction's data output equals the opposite port's input sampled at that edge (pass-through, one cycle later).
- R3: When a direction's latch enable is 0 and its strobe has not gone from 0 to 1 since the previous edge, its data output keeps its value even if the input changes.
- R4: With latch enable at 0, a 0-to-1 change of the strobe between two edges loads the input sampled at the second edge. A 1-to-0 change loads nothing.
- R5: When the latch enable drops while the strobe is already 1, the output keeps the last passed-through value. A later 1-to-0 then 0-to-1 strobe sequence loads new data.
- R6: `b_oe` equals `ab_oe` (1 = drive) sampled one edge earlier.
- R7: `a_oe` equals the inverse of `ba_oe_n` (0 = drive) sampled one edge earlier.
- R8: A disabled direction still passes, holds and loads data. Its data output shows the stored value whatever its enable is.
- R9: The two directions are independent: controls and data of one direction never change the other direction's outputs.
- R10: Each latch-enable high pulse lasts at least `MIN_LE_HIGH` system cycles, and each strobe level lasts at least `MIN_STROBE_LVL` system cycles. These are checked by assertions against the strobe and latch-enable levels seen since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 18 | Data sampled from port A |
| b_in | input | 18 | Data sampled from port B |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B latch enable (1 = pass-through) |
| ab_stb | input | 1 | A-to-B capture strobe (loads on a 0-to-1 change) |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable (1 = pass-through) |
| ba_stb | input | 1 | B-to-A capture strobe (loads on a 0-to-1 change) |
| b_out | output | 18 | Stored A-to-B value driven toward port B |
| b_oe | output | 1 | Port B drive enable (1 = drive, 0 = Z) |
| a_out | output | 18 | Stored B-to-A value driven toward port A |
| a_oe | output | 1 | Port A drive enable (1 = drive, 0 = Z) |

## Verification
The bench builds the block with the default width of 18 and with `MIN_LE_HIGH` and `MIN_STROBE_LVL` both at 2. At a 125 MHz system clock that gives a 16 ns minimum pulse, so the pulse-width assertions stay active while every stimulus remains legal. With the full 18-bit width, patterns such as alternating bits and all-ones reach every bit of both data paths. With only two-cycle minimum levels, a latch-enable fall while the strobe is high, followed by a full strobe period, fits within a handful of cycles. Those short levels also let the bench interleave activity on both directions to show they are independent.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_HOLD = 2'd1,
    MODE_LOAD = 2'd2
  } store_mode_t;

  function automatic store_mode_t pick_mode(input logic le, input logic rise);
    if (le)        return MODE_PASS;
    else if (rise) return MODE_LOAD;
    else           return MODE_HOLD;
  endfunction

endpackage

// File: rtl/xcvr_strobe.sv
module xcvr_strobe #(
  parameter int MIN_LE_HIGH    = 2,
  parameter int MIN_STROBE_LVL = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic le,
  input  logic stb,
  output logic rise
);
  localparam int LE_CW  = $clog2(MIN_LE_HIGH + 1) + 1;
  localparam int STB_CW = $clog2(MIN_STROBE_LVL + 1) + 1;
  localparam logic [LE_CW-1:0]  LE_SAT  = LE_CW'(MIN_LE_HIGH);
  localparam logic [STB_CW-1:0] STB_SAT = STB_CW'(MIN_STROBE_LVL);

  logic              stb_q;
  logic              le_q;
  logic [LE_CW-1:0]  le_run;
  logic [STB_CW-1:0] stb_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q   <= stb;
      le_q    <= le;
      le_run  <= LE_SAT;
      stb_run <= STB_SAT;
    end else begin
      stb_q <= stb;
      le_q  <= le;
      if (le && !le_q)          le_run <= LE_CW'(1);
      else if (le_run < LE_SAT) le_run <= le_run + LE_CW'(1);
      if (stb != stb_q)           stb_run <= STB_CW'(1);
      else if (stb_run < STB_SAT) stb_run <= stb_run + STB_CW'(1);
    end
  end

  assign rise = stb && !stb_q;

  // R10
  le_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    (le_q && !le) |-> (le_run >= LE_SAT));

  // R10
  stb_level_width_chk: assert property (@(posedge clk) disable iff (rst)
    (stb != stb_q) |-> (stb_run >= STB_SAT));

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int   WIDTH          = 18,
  parameter bit   OE_ACTIVE_LOW  = 1'b0,
  parameter int   MIN_LE_HIGH    = 2,
  parameter int   MIN_STROBE_LVL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             le,
  input  logic             stb,
  input  logic             oe_in,
  output logic [WIDTH-1:0] dout,
  output logic             oe_out
);
  logic        rise;
  store_mode_t mode;
  logic [WIDTH-1:0] held;
  logic             drive_q;

  xcvr_strobe #(
    .MIN_LE_HIGH   (MIN_LE_HIGH),
    .MIN_STROBE_LVL(MIN_STROBE_LVL)
  ) u_strobe (
    .clk (clk),
    .rst (rst),
    .le  (le),
    .stb (stb),
    .rise(rise)
  );

  assign mode = pick_mode(le, rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= '0;
      drive_q <= 1'b0;
    end else begin
      drive_q <= oe_in ^ OE_ACTIVE_LOW;
      unique case (mode)
        MODE_PASS, MODE_LOAD: held <= din;
        default:              held <= held;
      endcase
    end
  end

  assign dout   = held;
  assign oe_out = drive_q;

  // R2
  pass_follows_chk: assert property (@(posedge clk) disable iff (rst)
    le |=> (dout == $past(din)));

  // R3
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !rise) |=> $stable(dout));

  // R4
  edge_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && rise) |=> (dout == $past(din)));

  // R6
  enable_track_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_in ^ OE_ACTIVE_LOW) |=> oe_out);

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
  parameter int WIDTH          = 18,
  parameter int MIN_LE_HIGH    = 2,
  parameter int MIN_STROBE_LVL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_oe,
  input  logic             ab_le,
  input  logic             ab_stb,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_stb,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe
);
  localparam int NDIR = 2;

  logic [NDIR-1:0][WIDTH-1:0] src;
  logic [NDIR-1:0][WIDTH-1:0] dst;
  logic [NDIR-1:0]            le_v, stb_v, oe_v, drv_v;

  // index 0: A toward B, index 1: B toward A
  assign src   = {b_in, a_in};
  assign le_v  = {ba_le, ab_le};
  assign stb_v = {ba_stb, ab_stb};
  assign oe_v  = {ba_oe_n, ab_oe};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    xcvr_lane #(
      .WIDTH         (WIDTH),
      .OE_ACTIVE_LOW (d == 1),
      .MIN_LE_HIGH   (MIN_LE_HIGH),
      .MIN_STROBE_LVL(MIN_STROBE_LVL)
    ) u_lane (
      .clk   (clk),
      .rst   (rst),
      .din   (src[d]),
      .le    (le_v[d]),
      .stb   (stb_v[d]),
      .oe_in (oe_v[d]),
      .dout  (dst[d]),
      .oe_out(drv_v[d])
    );
  end

  assign b_out = dst[0];
  assign b_oe  = drv_v[0];
  assign a_out = dst[1];
  assign a_oe  = drv_v[1];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (a_out == '0 && b_out == '0 && !a_oe && !b_oe));

  // R7
  low_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ba_oe_n |=> !a_oe);

  // R9
  a_side_isolated_chk: assert property (@(posedge clk) disable iff (rst)
    (!ba_le && !(ba_stb && !$past(ba_stb))) |=> $stable(a_out));

endmodule

// File: tb/test_dual_path_xcvr.sv
module test_dual_path_xcvr;
  localparam int W = 18;

  typedef struct {
    logic [W-1:0] bo;
    logic [W-1:0] ao;
    logic         boe;
    logic         aoe;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe = 0, ab_le = 0, ab_stb = 0;
  logic ba_oe_n = 1, ba_le = 0, ba_stb = 0;
  logic [W-1:0] b_out, a_out;
  logic b_oe, a_oe;

  exp_t q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  logic [W-1:0] m_b = '0, m_a = '0;
  logic m_boe = 0, m_aoe = 0, p_ab = 0, p_ba = 0;

  always #4 clk = ~clk;

  dual_path_xcvr #(.WIDTH(W), .MIN_LE_HIGH(2), .MIN_STROBE_LVL(2)) i_dual_path_xcvr (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .ab_oe(ab_oe), .ab_le(ab_le), .ab_stb(ab_stb),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_stb(ba_stb),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe));

  task automatic tick(input string tag);
    exp_t e;
    @(posedge clk);
    if (rst) begin
      m_b = '0; m_a = '0; m_boe = 0; m_aoe = 0;
    end else begin
      if (ab_le || (ab_stb && !p_ab)) m_b = a_in;
      if (ba_le || (ba_stb && !p_ba)) m_a = b_in;
      m_boe = ab_oe;
      m_aoe = !ba_oe_n;
    end
    p_ab = ab_stb;
    p_ba = ba_stb;
    e.bo = m_b; e.ao = m_a; e.boe = m_boe; e.aoe = m_aoe; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: outputs settle after the edge, compare at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (b_out !== e.bo || a_out !== e.ao || b_oe !== e.boe || a_oe !== e.aoe) begin
        n_bad++;
        $display("FAIL %s: b_out=%h a_out=%h b_oe=%b a_oe=%b expected %h %h %b %b",
                 e.tag, b_out, a_out, b_oe, a_oe, e.bo, e.ao, e.boe, e.aoe);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset with a high strobe level present
    ab_stb = 1; a_in = 18'h3FFFF; b_in = 18'h15555;
    tick("R1"); tick("R1");
    rst = 0;
    // R1: the strobe level held during reset is no edge
    tick("R1"); tick("R1");
    ab_stb = 0; tick("R3"); tick("R3");

    // R2: pass-through A to B with several patterns
    ab_le = 1; ab_oe = 1;
    a_in = 18'h2AAAA; tick("R2");
    a_in = 18'h15555; tick("R2");
    a_in = 18'h3FFFF; tick("R2");
    // R5: strobe rises while passing, then latch enable drops with strobe high
    ab_stb = 1; a_in = 18'h01234; tick("R5"); tick("R5");
    ab_le = 0; a_in = 18'h3C3C3; tick("R5"); tick("R5");
    a_in = 18'h00F0F; tick("R3");
    // R4: falling strobe loads nothing
    ab_stb = 0; tick("R4"); tick("R4");
    // R4: rising strobe loads current A
    a_in = 18'h2BEEF; ab_stb = 1; tick("R4");
    a_in = 18'h11111; tick("R3"); tick("R3");
    // R10: minimum two-cycle strobe levels still load correctly
    ab_stb = 0; tick("R10"); tick("R10");
    a_in = 18'h0ACE1; ab_stb = 1; tick("R10"); tick("R10");

    // R6: A-to-B enable, active high
    ab_oe = 0; tick("R6"); tick("R6");
    ab_oe = 1; tick("R6");
    // R8: disabled direction keeps loading
    ab_oe = 0; ab_stb = 0; tick("R8"); tick("R8");
    a_in = 18'h3DEAD; ab_stb = 1; tick("R8"); tick("R8");
    ab_le = 1; a_in = 18'h00001; tick("R8"); tick("R8");
    ab_le = 0; tick("R8");

    // R7: B-to-A enable, active low
    ba_oe_n = 0; tick("R7"); tick("R7");
    ba_oe_n = 1; tick("R7");
    ba_oe_n = 0;
    // R2: pass-through B to A
    ba_le = 1; b_in = 18'h12345; tick("R2");
    b_in = 18'h2FEDC; tick("R2"); tick("R2");
    ba_le = 0; b_in = 18'h00000; tick("R3"); tick("R3");
    // R4: B-to-A load on strobe rise
    b_in = 18'h1CAFE; ba_stb = 1; tick("R4"); tick("R4");
    ba_stb = 0; b_in = 18'h3FFFF; tick("R4"); tick("R4");

    // R9: activity on A-to-B leaves A side alone, and the reverse
    ab_le = 1; a_in = 18'h24680; tick("R9");
    a_in = 18'h13579; tick("R9");
    ab_le = 0; tick("R9");
    ba_le = 1; b_in = 18'h0BEEF; tick("R9"); tick("R9");
    ba_le = 0; a_in = 18'h3AAAA; tick("R9"); tick("R9");
    // R8: B-to-A disabled while loading
    ba_oe_n = 1; b_in = 18'h05A5A; ba_stb = 1; tick("R8"); tick("R8");
    ba_stb = 0; tick("R8"); tick("R8");

    // R1: reset mid-run clears stored data and enables
    rst = 1; tick("R1"); rst = 0; ba_oe_n = 1; ab_oe = 0; tick("R1"); tick("R1");

    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule